// File: doc/BRIEF.md
# Flip-Flop Register-File FIFO Queue

A short synchronous first-in first-out queue meant for the input ports of an on-chip network router. Storage is a bank of D entries, each W flip-flops wide, with no memory macro. A one-hot write pointer picks the single entry that captures an accepted word. A one-hot read pointer selects the oldest entry onto the output through an AND-OR multiplexer. Stored words never move between entries. On each accepted operation the matching pointer rotates by one position, wrapping from the last entry to entry 0.

Every flip-flop receives the same free-running clock. An entry keeps its value because its load enable stays low. The per-entry load enables are brought out on a port of their own, so that a synthesis flow can turn each one into a clock-gating condition. The output is first-word-fall-through: whenever the queue is not empty, the head word is present combinationally on the data output. A stall output tells the upstream sender to stop one entry before the queue is full. That one-entry margin covers a sender that takes one cycle to react.

Top module: `ffrf_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, stall is 0 and every bit of load_en is 0.
- R2: Words leave in the order they were accepted. While empty is 0, rd_data equals the oldest stored word in the same cycle, with no read needed to present it.
- R3: An accepted write (wr_en high and full low) raises exactly one bit of load_en. After reset the first accepted write uses bit 0. Each later accepted write uses the next higher bit, and bit D-1 is followed by bit 0.
- R4: Ordering from R2 holds across any number of wraps of both pointers past entry D-1.
- R5: full is 1 exactly when D words are held. empty is 1 exactly when no word is held.
- R6: wr_en while full (with no read) is ignored: load_en stays all 0 and the stored words and their order are unchanged.
- R7: rd_en while empty is ignored: the queue stays empty, and a later write is presented on rd_data as the head.
- R8: stall is 1 exactly when the number of held words is at least D-1.
- R9: A read and a write in the same cycle on a queue that is neither empty nor full both take effect and leave the number of held words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock to every flip-flop |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Offer wr_data for storage |
| wr_data | input | W | Incoming word |
| rd_en | input | 1 | Remove the head word |
| rd_data | output | W | Head word (valid while empty is 0) |
| empty | output | 1 | No word held |
| full | output | 1 | D words held |
| stall | output | 1 | Back-pressure to the sender, at D-1 or more words |
| load_en | output | D | Per-entry load enables, one-hot on an accepted write |

## Verification
The bench builds the queue with D=5 and W=12. A depth that is not a power of two makes the rotation wrap at entry 4 while the occupancy counter can count to 7. This exposes any full or wrap logic that relies on counter overflow instead of comparing with D. The 12-bit width catches slicing errors in the output multiplexer. The depth is shallow enough that random traffic reaches full, the stall threshold and many pointer wraps within a few thousand cycles.

// File: rtl/ffrf_fifo.sv
module ffrf_fifo #(
  parameter int W = 8,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         stall,
  output logic [D-1:0] load_en
);
  localparam int CW = $clog2(D + 1);

  logic [D-1:0]  head, tail;
  logic [CW-1:0] count;
  logic [W-1:0]  ent [D];
  logic          wr_ok, rd_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(D));
  assign stall   = (count >= CW'(D - 1));
  assign wr_ok   = wr_en & ~full;
  assign rd_ok   = rd_en & ~empty;
  assign load_en = wr_ok ? tail : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= D'(1);
      tail  <= D'(1);
      count <= '0;
    end else begin
      if (wr_ok) tail <= {tail[D-2:0], tail[D-1]};
      if (rd_ok) head <= {head[D-2:0], head[D-1]};
      if (wr_ok && !rd_ok)      count <= count + 1'b1;
      else if (rd_ok && !wr_ok) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < D; i++) begin : g_ent
    always_ff @(posedge clk)
      if (load_en[i]) ent[i] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < D; i++)
      if (head[i]) rd_data = rd_data | ent[i];
  end
endmodule

module ffrf_fifo_chk #(
  parameter int W = 8,
  parameter int D = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         rd_en,
  input logic         empty,
  input logic         full,
  input logic         stall,
  input logic [D-1:0] load_en,
  input logic [D-1:0] head,
  input logic [D-1:0] tail
);
  a_r3_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_en));
  a_r3_load_when_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full) |-> ($countones(load_en) == 1));
  a_r4_ptrs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(head) == 1) && ($countones(tail) == 1));
  a_r5_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r6_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> (full && tail == $past(tail) && head == $past(head)));
  a_r7_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> (empty && head == $past(head)));
  a_r8_stall_at_full: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> stall);
  a_r9_both_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && !empty && !full) |=> ($stable(empty) && $stable(full) && $stable(stall)));
endmodule

bind ffrf_fifo ffrf_fifo_chk #(.W(W), .D(D)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .empty(empty), .full(full), .stall(stall), .load_en(load_en),
  .head(head), .tail(tail)
);

// File: tb/ffrf_fifo_test.sv
`timescale 1ns/1ps
module ffrf_fifo_test;
  localparam int W = 12;
  localparam int D = 5;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         wr_en = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         empty, full, stall;
  logic [D-1:0] load_en;

  ffrf_fifo #(.W(W), .D(D)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .full(full), .stall(stall), .load_en(load_en)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] q [D];
  int hd = 0, tl = 0, cnt = 0, nwr = 0;

  function automatic bit exp_stall(int c); return c >= D - 1; endfunction
  function automatic logic [D-1:0] exp_load(bit w, int c, int t);
    return (w && c < D) ? D'(1) << t : '0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk(empty === (cnt == 0), req, 64'(empty), 64'(cnt == 0));
    chk(full === (cnt == D), req, 64'(full), 64'(cnt == D));
    chk(stall === exp_stall(cnt), req, 64'(stall), 64'(exp_stall(cnt)));
  endtask

  task automatic step(input bit w, input logic [W-1:0] d, input bit r);
    logic [D-1:0] el;
    bit wok, rok;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    #1;
    chk(empty === (cnt == 0), "R5", 64'(empty), 64'(cnt == 0));
    chk(full === (cnt == D), "R5", 64'(full), 64'(cnt == D));
    chk(stall === exp_stall(cnt), "R8", 64'(stall), 64'(exp_stall(cnt)));
    el = exp_load(w, cnt, tl);
    chk(load_en === el, (w && cnt == D) ? "R6" : "R3", 64'(load_en), 64'(el));
    if (cnt > 0)
      chk(rd_data === q[hd], (nwr > D) ? "R4" : "R2", 64'(rd_data), 64'(q[hd]));
    @(posedge clk);
    wok = w && cnt < D;
    rok = r && cnt > 0;
    if (wok) begin q[tl] = d; tl = (tl + 1) % D; nwr++; end
    if (rok) hd = (hd + 1) % D;
    cnt = cnt + int'(wok) - int'(rok);
  endtask

  task automatic probe(input string req);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    #1;
    chk_flags(req);
    if (cnt > 0) chk(rd_data === q[hd], req, 64'(rd_data), 64'(q[hd]));
    @(posedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    chk(empty === 1'b1, "R1", 64'(empty), 1);
    chk(full === 1'b0, "R1", 64'(full), 0);
    chk(stall === 1'b0, "R1", 64'(stall), 0);
    chk(load_en === '0, "R1", 64'(load_en), 0);

    // R7: reads on empty queue ignored, then a write becomes head
    step(0, '0, 1);
    step(0, '0, 1);
    probe("R7");
    step(1, 12'hA5C, 1);
    probe("R7");
    chk(rd_data === 12'hA5C, "R7", 64'(rd_data), 64'h A5C);

    // fill to full, then R6: extra writes ignored
    for (int i = 0; i < D; i++) step(1, 12'(12'h100 + i), 0);
    probe("R5");
    step(1, 12'hFFF, 0);
    step(1, 12'hEEE, 0);
    probe("R6");
    for (int i = 0; i < D; i++) step(0, '0, 1);
    probe("R6");

    // R9: simultaneous read and write at mid level
    step(1, 12'h321, 0);
    step(1, 12'h654, 0);
    for (int i = 0; i < 2 * D + 1; i++) step(1, 12'(12'h700 + i), 1);
    probe("R9");
    for (int i = 0; i < 3; i++) step(0, '0, 1);

    // random traffic with bias phases for R2 R4 R8
    for (int i = 0; i < 4000; i++) begin
      int bias = (i / 250) % 3;
      bit w = ($urandom_range(99) < (bias == 0 ? 75 : bias == 1 ? 25 : 50));
      bit r = ($urandom_range(99) < (bias == 0 ? 25 : bias == 1 ? 75 : 50));
      step(w, 12'($urandom), r);
    end
    probe("R4");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule